// File: doc/BRIEF.md
# USB Link Power State Controller

This block follows the power state of a USB link for a controller that can act as either host or peripheral. It keeps one of four states: L0 (active), L1 (sleep), L2 (suspend) and L3 (off). Bus activity, millisecond ticks, role, register controls and the outcomes of bus events arrive as abstract one-bit inputs. The block turns them into the current link state, a suspend interrupt, the suspend and power-down indications, a strobe for the peripheral reset actions, and the host-side reset drive and frame-counter run enable.

A peripheral that sees no bus activity for a set number of millisecond ticks drops into suspend. An acknowledged link power management request moves the link to sleep. Resume signalling or a permitted remote wake brings it back to active. A disconnect, power loss or disable event sends the link to off from any state, and only an enable event brings it out of off. When several events land in the same cycle, a fixed priority decides the result: drop first, then reset, then resume or wake, then the sleep request, then the idle timeout.

Top module: `link_power_ctrl`

## Requirements
- R1: After a synchronous reset, link_state reads 3 (encoding: 0 = L0, 1 = L1, 2 = L2, 3 = L3), suspendm_n is 1, and powerdwn, susp_irq, rst_action, reset_drive and frame_run are all 0.
- R2: In L3 the link stays in L3 until enable_evt is sampled, and then moves to L0 one cycle later. reset_req, resume_evt, wake_evt, lpm_ack and ms_tick have no effect in L3, and no rst_action is produced there.
- R3: In peripheral role (role_host = 0), the link moves from L0 to L2 in the cycle after the IDLE_MS-th ms_tick (default 3) counted with bus_active low. A cycle with bus_active high, including one that coincides with a tick, restarts the count from zero.
- R4: susp_irq is a one-cycle pulse that appears in the same cycle link_state first reads 2, and only when susp_irq_en is 1.
- R5: While link_state is 2, powerdwn is 1 and suspendm_n equals the inverse of suspm_out_en. Both return to their idle values (powerdwn 0, suspendm_n 1) in the same cycle that link_state returns to 0.
- R6: lpm_ack sampled in L0 moves the link to L1 one cycle later. In L1, powerdwn stays 0 and suspendm_n stays 1.
- R7: resume_evt sampled in L1 or L2 returns the link to L0 one cycle later.
- R8: wake_evt returns the link to L0 from L1 only if lpm_wake_en was 1 in the cycle of the lpm_ack that entered L1. It returns the link to L0 from L2 only if feat_wake_en is 1. Otherwise the link keeps its state.
- R9: drop_evt moves the link to L3 one cycle later from any state, overriding every other event in the same cycle.
- R10: In peripheral role, a rising edge of reset_req in L0, L1 or L2 moves the link to L0 and gives one rst_action pulse in the next cycle, however long reset_req is held. Such a reset also restarts the idle count.
- R11: In host role, reset_drive follows reset_req one cycle late while the link is not in L3. frame_run rises one cycle after reset_req falls and stays high until reset_req is asserted again, the role changes to peripheral, or the link enters L3.
- R12: In host role, idle ticks never move the link from L0 to L2.
- R13: Events in the same cycle resolve in this order: reset over resume/wake, resume/wake over lpm_ack, and lpm_ack over the idle timeout (the coinciding tick then produces neither L2 nor susp_irq).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| role_host | input | 1 | 1 = host role, 0 = peripheral role |
| bus_active | input | 1 | Bus activity seen this cycle |
| ms_tick | input | 1 | One-cycle millisecond tick |
| reset_req | input | 1 | Peripheral: bus reset detected; host: reset control bit |
| susp_irq_en | input | 1 | Enable for the suspend interrupt |
| suspm_out_en | input | 1 | Enable for the suspendm_n output |
| lpm_ack | input | 1 | Link power management request acknowledged |
| lpm_wake_en | input | 1 | Remote-wake permission carried by the acknowledged request |
| feat_wake_en | input | 1 | Remote-wake permission granted by set-feature |
| resume_evt | input | 1 | Resume signalling detected |
| wake_evt | input | 1 | Remote wake requested |
| drop_evt | input | 1 | Disconnect, power loss or disable |
| enable_evt | input | 1 | Reset-and-enable of a powered-off link |
| link_state | output | 2 | Current link state (0..3 = L0..L3) |
| susp_irq | output | 1 | Suspend interrupt pulse |
| suspendm_n | output | 1 | Active-low suspend indication |
| powerdwn | output | 1 | Clock may be stopped |
| rst_action | output | 1 | Strobe: flush FIFOs, clear registers, enable endpoint interrupts, raise reset interrupt |
| reset_drive | output | 1 | Host reset signalling active |
| frame_run | output | 1 | Host frame counter and scheduler enable |

## Verification
The hardest case to reach from the ports is the gating of remote wake in L1. The permission is captured only in the cycle of the sleep acknowledge, so the stimulus changes lpm_wake_en right after the acknowledge and shows that the later wake follows the captured value, not the live one. The test sweeps every combination of target state, sleep-time permission and set-feature permission. A second hard case is the collision of the idle timeout with other events: the count is walked to one tick short of expiry, and the final tick is then paired with a sleep request or a reset in the same cycle.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  typedef enum logic [1:0] {
    LNK_ON    = 2'd0,
    LNK_SLEEP = 2'd1,
    LNK_SUSP  = 2'd2,
    LNK_OFF   = 2'd3
  } lnk_t;
endpackage

// File: rtl/lpc_idle_timer.sv
module lpc_idle_timer #(
  parameter int unsigned IDLE_MS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic activity,
  input  logic ms_tick,
  output logic expire
);
  localparam int unsigned CW = $clog2(IDLE_MS + 1);
  localparam logic [CW-1:0] LAST = CW'(IDLE_MS - 1);

  logic [CW-1:0] cnt;

  // the tick that completes the window fires immediately
  assign expire = run && !activity && ms_tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || activity) begin
      cnt <= '0;
    end else if (ms_tick && !expire) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lpc_state_fsm.sv
module lpc_state_fsm
  import lpc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic drop_evt,
  input  logic enable_evt,
  input  logic reset_req,
  input  logic resume_evt,
  input  logic wake_evt,
  input  logic lpm_ack,
  input  logic lpm_wake_en,
  input  logic feat_wake_en,
  input  logic timeout,
  output lnk_t state,
  output lnk_t nxt
);
  logic lpm_wake_q;
  logic wake_ok;

  assign wake_ok = (state == LNK_SLEEP) ? lpm_wake_q : feat_wake_en;

  always_comb begin
    nxt = state;
    if (drop_evt) begin
      nxt = LNK_OFF;
    end else if (state == LNK_OFF) begin
      if (enable_evt) nxt = LNK_ON;
    end else if (reset_req) begin
      nxt = LNK_ON;
    end else if ((state != LNK_ON) && (resume_evt || (wake_evt && wake_ok))) begin
      nxt = LNK_ON;
    end else if ((state == LNK_ON) && lpm_ack) begin
      nxt = LNK_SLEEP;
    end else if ((state == LNK_ON) && timeout) begin
      nxt = LNK_SUSP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= LNK_OFF;
      lpm_wake_q <= 1'b0;
    end else begin
      state <= nxt;
      if ((state == LNK_ON) && (nxt == LNK_SLEEP)) begin
        lpm_wake_q <= lpm_wake_en;
      end
    end
  end
endmodule

// File: rtl/lpc_reset_seq.sv
module lpc_reset_seq (
  input  logic clk,
  input  logic rst,
  input  logic role_host,
  input  logic reset_req,
  input  logic drop_evt,
  input  logic state_off,
  input  logic nxt_off,
  output logic rst_action,
  output logic reset_drive,
  output logic frame_run
);
  logic req_q;
  logic accept;

  assign accept = !state_off && !drop_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q       <= 1'b0;
      rst_action  <= 1'b0;
      reset_drive <= 1'b0;
      frame_run   <= 1'b0;
    end else begin
      req_q       <= reset_req;
      rst_action  <= !role_host && accept && reset_req && !req_q;
      reset_drive <= role_host && accept && reset_req;
      if (!role_host || nxt_off || reset_req) begin
        frame_run <= 1'b0;
      end else if (req_q) begin
        frame_run <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/link_power_ctrl.sv
module link_power_ctrl
  import lpc_pkg::*;
#(
  parameter int unsigned IDLE_MS = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       role_host,
  input  logic       bus_active,
  input  logic       ms_tick,
  input  logic       reset_req,
  input  logic       susp_irq_en,
  input  logic       suspm_out_en,
  input  logic       lpm_ack,
  input  logic       lpm_wake_en,
  input  logic       feat_wake_en,
  input  logic       resume_evt,
  input  logic       wake_evt,
  input  logic       drop_evt,
  input  logic       enable_evt,
  output logic [1:0] link_state,
  output logic       susp_irq,
  output logic       suspendm_n,
  output logic       powerdwn,
  output logic       rst_action,
  output logic       reset_drive,
  output logic       frame_run
);
  lnk_t state;
  lnk_t nxt;
  logic timeout;
  logic idle_run;

  assign idle_run = (state == LNK_ON) && !role_host && !reset_req;

  lpc_idle_timer #(.IDLE_MS(IDLE_MS)) u_idle (
    .clk      (clk),
    .rst      (rst),
    .run      (idle_run),
    .activity (bus_active),
    .ms_tick  (ms_tick),
    .expire   (timeout)
  );

  lpc_state_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .drop_evt     (drop_evt),
    .enable_evt   (enable_evt),
    .reset_req    (reset_req),
    .resume_evt   (resume_evt),
    .wake_evt     (wake_evt),
    .lpm_ack      (lpm_ack),
    .lpm_wake_en  (lpm_wake_en),
    .feat_wake_en (feat_wake_en),
    .timeout      (timeout),
    .state        (state),
    .nxt          (nxt)
  );

  lpc_reset_seq u_rseq (
    .clk         (clk),
    .rst         (rst),
    .role_host   (role_host),
    .reset_req   (reset_req),
    .drop_evt    (drop_evt),
    .state_off   (state == LNK_OFF),
    .nxt_off     (nxt == LNK_OFF),
    .rst_action  (rst_action),
    .reset_drive (reset_drive),
    .frame_run   (frame_run)
  );

  assign link_state = state;

  // suspend indications registered from the next state so they line up with link_state
  always_ff @(posedge clk) begin
    if (rst) begin
      susp_irq   <= 1'b0;
      powerdwn   <= 1'b0;
      suspendm_n <= 1'b1;
    end else begin
      susp_irq   <= (state == LNK_ON) && (nxt == LNK_SUSP) && susp_irq_en;
      powerdwn   <= (nxt == LNK_SUSP);
      suspendm_n <= !((nxt == LNK_SUSP) && suspm_out_en);
    end
  end
endmodule

// File: rtl/lpc_checker.sv
module lpc_checker (
  input logic       clk,
  input logic       rst,
  input logic       role_host,
  input logic       reset_req,
  input logic       drop_evt,
  input logic       enable_evt,
  input logic [1:0] link_state,
  input logic       susp_irq,
  input logic       powerdwn,
  input logic       rst_action,
  input logic       reset_drive
);
  AST_DROP_TO_OFF: assert property (@(posedge clk) disable iff (rst) drop_evt |=> link_state == 2'd3); // R9
  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (rst) (link_state == 2'd3 && !enable_evt) |=> link_state == 2'd3); // R2
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst) susp_irq |=> !susp_irq); // R4
  AST_IRQ_AT_ENTRY: assert property (@(posedge clk) disable iff (rst) susp_irq |-> (link_state == 2'd2 && $past(link_state) == 2'd0)); // R4
  AST_PWRDN_MATCH: assert property (@(posedge clk) disable iff (rst) powerdwn == (link_state == 2'd2)); // R5
  AST_HOST_NO_IDLE: assert property (@(posedge clk) disable iff (rst) (role_host && link_state == 2'd0) |=> link_state != 2'd2); // R12
  AST_RST_ACT_ON: assert property (@(posedge clk) disable iff (rst) rst_action |-> link_state == 2'd0); // R10
  AST_RST_ACT_SINGLE: assert property (@(posedge clk) disable iff (rst) rst_action |=> !rst_action); // R10
  AST_DRIVE_FOLLOWS: assert property (@(posedge clk) disable iff (rst) reset_drive |-> $past(reset_req)); // R11
endmodule

bind link_power_ctrl lpc_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .role_host   (role_host),
  .reset_req   (reset_req),
  .drop_evt    (drop_evt),
  .enable_evt  (enable_evt),
  .link_state  (link_state),
  .susp_irq    (susp_irq),
  .powerdwn    (powerdwn),
  .rst_action  (rst_action),
  .reset_drive (reset_drive)
);

// File: tb/tb_link_power_ctrl.sv
module tb_link_power_ctrl;
  localparam int IDLE_MS = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic role_host = 0, bus_active = 0, ms_tick = 0, reset_req = 0;
  logic susp_irq_en = 0, suspm_out_en = 0, lpm_ack = 0, lpm_wake_en = 0;
  logic feat_wake_en = 0, resume_evt = 0, wake_evt = 0, drop_evt = 0, enable_evt = 0;
  logic [1:0] link_state;
  logic susp_irq, suspendm_n, powerdwn, rst_action, reset_drive, frame_run;

  int n_tests = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  link_power_ctrl #(.IDLE_MS(IDLE_MS)) dut (
    .clk(clk), .rst(rst), .role_host(role_host), .bus_active(bus_active),
    .ms_tick(ms_tick), .reset_req(reset_req), .susp_irq_en(susp_irq_en),
    .suspm_out_en(suspm_out_en), .lpm_ack(lpm_ack), .lpm_wake_en(lpm_wake_en),
    .feat_wake_en(feat_wake_en), .resume_evt(resume_evt), .wake_evt(wake_evt),
    .drop_evt(drop_evt), .enable_evt(enable_evt), .link_state(link_state),
    .susp_irq(susp_irq), .suspendm_n(suspendm_n), .powerdwn(powerdwn),
    .rst_action(rst_action), .reset_drive(reset_drive), .frame_run(frame_run)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic to_off();
    drop_evt = 1; cyc(1); drop_evt = 0;
  endtask

  task automatic to_on();
    to_off();
    enable_evt = 1; cyc(1); enable_evt = 0;
  endtask

  task automatic tick();
    ms_tick = 1; cyc(1); ms_tick = 0; cyc(1);
  endtask

  initial begin
    cyc(400000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    cyc(3); rst = 0; cyc(1);
    // R1 reset values
    chk("R1 state", link_state, 3);
    chk("R1 suspendm_n", suspendm_n, 1);
    chk("R1 powerdwn", powerdwn, 0);
    chk("R1 susp_irq", susp_irq, 0);
    chk("R1 rst_action", rst_action, 0);
    chk("R1 reset_drive", reset_drive, 0);
    chk("R1 frame_run", frame_run, 0);

    // R2 events ignored in L3
    feat_wake_en = 1;
    reset_req = 1; cyc(1); reset_req = 0;
    chk("R2 reset ignored", link_state, 3); chk("R2 no rst_action", rst_action, 0);
    resume_evt = 1; wake_evt = 1; lpm_ack = 1; cyc(1);
    resume_evt = 0; wake_evt = 0; lpm_ack = 0;
    chk("R2 resume/wake/lpm ignored", link_state, 3);
    for (int k = 0; k < 5; k++) tick();
    chk("R2 ticks ignored", link_state, 3);
    feat_wake_en = 0;
    enable_evt = 1; cyc(1); enable_evt = 0;
    chk("R2 enable exits", link_state, 0);

    // R3 R4 R5 R7: sweep tick count and output enables
    for (int ie = 0; ie < 2; ie++)
      for (int oe = 0; oe < 2; oe++)
        for (int n = 0; n <= 5; n++) begin
          to_on();
          susp_irq_en = 1'(ie); suspm_out_en = 1'(oe);
          for (int k = 1; k <= n; k++) begin
            ms_tick = 1; cyc(1); ms_tick = 0;
            if (k == IDLE_MS) begin
              chk("R3 enter L2", link_state, 2);
              chk("R4 irq on entry", susp_irq, ie);
              chk("R5 powerdwn", powerdwn, 1);
              chk("R5 suspendm_n", suspendm_n, 1 - oe);
            end else begin
              chk("R4 no irq", susp_irq, 0);
            end
            cyc(1);
            chk("R4 irq single", susp_irq, 0);
          end
          chk("R3 state after ticks", link_state, (n >= IDLE_MS) ? 2 : 0);
          resume_evt = 1; cyc(1); resume_evt = 0;
          chk("R7 resume", link_state, 0);
          chk("R5 powerdwn released", powerdwn, 0);
          chk("R5 suspendm_n released", suspendm_n, 1);
        end
    susp_irq_en = 1; suspm_out_en = 1;

    // R3 activity restarts count
    to_on();
    tick(); tick();
    bus_active = 1; cyc(1); bus_active = 0;
    tick(); tick();
    chk("R3 restart by activity", link_state, 0);
    tick();
    chk("R3 expire after restart", link_state, 2);
    to_on();
    tick(); tick();
    ms_tick = 1; bus_active = 1; cyc(1); ms_tick = 0; bus_active = 0;
    chk("R3 tick with activity", link_state, 0);
    tick(); tick();
    chk("R3 restarted window", link_state, 0);
    tick();
    chk("R3 expire", link_state, 2);

    // R6 R7 R8 wake permission sweep
    for (int t = 0; t < 2; t++)
      for (int lw = 0; lw < 2; lw++)
        for (int fw = 0; fw < 2; fw++) begin
          to_on();
          feat_wake_en = 1'(fw);
          if (t == 0) begin
            lpm_wake_en = 1'(lw); lpm_ack = 1; cyc(1); lpm_ack = 0;
            lpm_wake_en = 1'(1 - lw);
            chk("R6 enter L1", link_state, 1);
            chk("R6 powerdwn", powerdwn, 0);
            chk("R6 suspendm_n", suspendm_n, 1);
          end else begin
            lpm_wake_en = 1'(lw);
            tick(); tick(); tick();
            chk("R3 enter L2", link_state, 2);
          end
          wake_evt = 1; cyc(1); wake_evt = 0;
          chk("R8 wake gating", link_state,
              ((t == 0) ? lw : fw) ? 0 : ((t == 0) ? 1 : 2));
          resume_evt = 1; cyc(1); resume_evt = 0;
          chk("R7 resume", link_state, 0);
        end
    lpm_wake_en = 0; feat_wake_en = 0;

    // R9 drop overrides from L0, L1, L2
    for (int s = 0; s < 3; s++) begin
      to_on();
      if (s == 1) begin lpm_ack = 1; cyc(1); lpm_ack = 0; end
      if (s == 2) begin tick(); tick(); tick(); end
      chk("R9 setup", link_state, s);
      drop_evt = 1; resume_evt = 1; reset_req = 1; cyc(1);
      drop_evt = 0; resume_evt = 0; reset_req = 0;
      chk("R9 drop to L3", link_state, 3);
      chk("R9 no rst_action", rst_action, 0);
    end

    // R10 peripheral reset
    to_on();
    reset_req = 1; cyc(1);
    chk("R10 strobe", rst_action, 1);
    cyc(1); chk("R10 strobe single", rst_action, 0);
    cyc(1); chk("R10 held no strobe", rst_action, 0);
    reset_req = 0; cyc(1);
    tick(); tick(); tick();
    chk("R10 setup L2", link_state, 2);
    reset_req = 1; cyc(1); reset_req = 0;
    chk("R10 reset from L2", link_state, 0);
    chk("R10 strobe from L2", rst_action, 1);
    tick(); tick();
    reset_req = 1; cyc(1); reset_req = 0;
    tick(); tick();
    chk("R10 reset restarts count", link_state, 0);
    tick();
    chk("R10 expire after reset", link_state, 2);

    // R11 R12 host role
    role_host = 1;
    to_on();
    reset_req = 1; cyc(1);
    chk("R11 drive on", reset_drive, 1);
    chk("R11 frame off", frame_run, 0);
    chk("R11 no strobe in host", rst_action, 0);
    cyc(3); chk("R11 drive held", reset_drive, 1);
    reset_req = 0; cyc(1);
    chk("R11 drive off", reset_drive, 0);
    chk("R11 frame on", frame_run, 1);
    cyc(3); chk("R11 frame held", frame_run, 1);
    for (int k = 0; k < 6; k++) tick();
    chk("R12 host no suspend", link_state, 0);
    chk("R12 no irq", susp_irq, 0);
    chk("R12 no powerdwn", powerdwn, 0);
    reset_req = 1; cyc(1);
    chk("R11 frame cleared by reset", frame_run, 0);
    reset_req = 0; cyc(1);
    chk("R11 frame restarts", frame_run, 1);
    drop_evt = 1; cyc(1); drop_evt = 0;
    chk("R11 frame cleared by L3", frame_run, 0);
    reset_req = 1; cyc(1);
    chk("R11 no drive in L3", reset_drive, 0);
    reset_req = 0;
    enable_evt = 1; cyc(1); enable_evt = 0;
    reset_req = 1; cyc(1); reset_req = 0; cyc(1);
    chk("R11 frame on again", frame_run, 1);
    role_host = 0; cyc(1);
    chk("R11 frame cleared by role", frame_run, 0);

    // R13 priority
    to_on();
    tick(); tick();
    ms_tick = 1; lpm_ack = 1; cyc(1); ms_tick = 0; lpm_ack = 0;
    chk("R13 lpm over timeout", link_state, 1);
    chk("R13 no irq", susp_irq, 0);
    reset_req = 1; resume_evt = 1; cyc(1); reset_req = 0; resume_evt = 0;
    chk("R13 reset over resume", link_state, 0);
    chk("R13 reset strobe", rst_action, 1);
    tick(); tick();
    ms_tick = 1; reset_req = 1; cyc(1); ms_tick = 0; reset_req = 0;
    chk("R13 reset over timeout", link_state, 0);
    chk("R13 strobe", rst_action, 1);
    reset_req = 1; lpm_ack = 1; cyc(1); reset_req = 0; lpm_ack = 0;
    chk("R13 reset over lpm", link_state, 0);
    lpm_ack = 1; cyc(1); lpm_ack = 0;
    tick(); tick(); tick();
    chk("R13 L1 ignores ticks", link_state, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule